// File: doc/BRIEF.md
# Card wait-state controller

This block keeps the protocol state of a proximity card. The state is one of idle, ready, active or halt. The block takes one decoded frame at a time from the receive path. Each frame comes with a strobe, an error flag, a short-frame flag, a byte count and its first two bytes.

A wake or request short frame moves the card from a wait state to ready. A selection pulse from the anticollision unit moves it from ready to active. A valid halt frame parks an active card in halt. After a wake from halt, a failed exchange sends the card back to halt and not to idle, so a handled card stays apart from the cards not yet selected.

The block also produces a one-cycle respond enable that tells the transmit path to send an answer. It asserts it after an accepted wake or request, and after any valid frame that another unit claims while the card is ready or active. It never asserts it for a halt, for an error or while the card is in halt.

Top module: `card_wait_ctrl`

## Requirements
- R1: Driving rst_ni low forces state_o to idle (encoding 0), woken_o to 0 and resp_en_o to 0 at once, without waiting for a clock edge, including in the middle of operation.
- R2: In idle, an error-free short frame whose low 7 bits equal 0x26 (request) or 0x52 (wake) moves state_o to ready (1) on the next edge, clears woken_o and raises resp_en_o for one cycle. Any other frame, errored or not, leaves idle unchanged with resp_en_o low.
- R3: In halt (3), only an error-free short frame 0x52 moves the card to ready, sets woken_o and raises resp_en_o. Every other input leaves state_o at halt and resp_en_o low: a request frame, a halt frame, a claimed frame, an errored wake frame or a selection pulse.
- R4: sel_done_i moves ready to active (2) on the next edge when no frame arrives in the same cycle. It has no effect in idle, active or halt.
- R5: In active, a halt frame (error-free, not short, byte count 2, bytes 0x50 then 0x00) moves the card to halt. It also clears woken_o and gives no response.
- R6: A halt frame received in ready is treated as unexpected. So is a halt-like frame received in active with an error flag, a wrong second byte or a wrong byte count. None of these enters halt through the halt command; each takes the fallback of R7.
- R7: In ready or active, an errored frame, any short frame or an unclaimed frame moves the card to its fallback: halt if woken_o is 1, otherwise idle. woken_o clears and resp_en_o stays low.
- R8: In ready or active, an error-free, non-halt frame with claim_i high keeps the state and woken_o, and raises resp_en_o for one cycle.
- R9: resp_en_o is high only in the cycle after an accepted frame, as R2, R3 and R8 define it.
- R10: When a frame and sel_done_i arrive in the same cycle in ready, the frame is acted on and the selection pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous field reset |
| frame_vld_i | input | 1 | One-cycle strobe for a received frame |
| frame_err_i | input | 1 | Frame had a parity, CRC or bit-count error |
| frame_short_i | input | 1 | Frame is a 7-bit short frame |
| frame_len_i | input | LEN_W | Byte count of a standard frame |
| frame_b0_i | input | 8 | First byte; a short frame sits in bits 6:0 |
| frame_b1_i | input | 8 | Second byte |
| claim_i | input | 1 | Another unit accepts the frame in its own right |
| sel_done_i | input | 1 | Anticollision unit finished selection |
| state_o | output | 2 | 0 idle, 1 ready, 2 active, 3 halt |
| woken_o | output | 1 | The card left halt through a wake frame |
| resp_en_o | output | 1 | Transmit path may answer |

## Verification
The bench builds the block with its default parameters: 7-bit short codes 0x26 and 0x52, a 5-bit byte count and halt bytes 0x50 0x00. With these values the directed sequences can reach every state pair, including the halt-to-ready-to-halt paths that the woken flag selects. Near-miss frames sit one field away from a real command (wrong code, error flag, wrong second byte, wrong length). A long stretch of mixed random frames checks every cycle against the behavioural model, so inputs that arrive together are also covered.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READY  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HALT   = 2'd3
  } cwc_state_e;

  typedef struct packed {
    logic vld;    // frame present
    logic ok;     // present and error free
    logic short;  // short frame
    logic reqa;   // valid request
    logic wupa;   // valid wake
    logic halt;   // valid halt command
  } cwc_cmd_t;
endpackage

// File: rtl/cwc_decode.sv
module cwc_decode
  import cwc_pkg::*;
#(
  parameter int unsigned SHORT_W = 7,
  parameter int unsigned LEN_W = 5,
  parameter logic [SHORT_W-1:0] REQ_CODE = 7'h26,
  parameter logic [SHORT_W-1:0] WAKE_CODE = 7'h52,
  parameter logic [7:0] HALT_OP = 8'h50,
  parameter logic [7:0] HALT_ARG = 8'h00
) (
  input  logic             vld_i,
  input  logic             err_i,
  input  logic             short_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       b0_i,
  input  logic [7:0]       b1_i,
  output cwc_cmd_t         cmd_o
);
  localparam logic [LEN_W-1:0] HaltLen = LEN_W'(2);

  logic ok;
  logic [SHORT_W-1:0] code;

  assign ok   = vld_i & ~err_i;
  assign code = b0_i[SHORT_W-1:0];

  always_comb begin
    cmd_o       = '0;
    cmd_o.vld   = vld_i;
    cmd_o.ok    = ok;
    cmd_o.short = vld_i & short_i;
    cmd_o.reqa  = ok & short_i & (code == REQ_CODE);
    cmd_o.wupa  = ok & short_i & (code == WAKE_CODE);
    cmd_o.halt  = ok & ~short_i & (len_i == HaltLen) &
                  (b0_i == HALT_OP) & (b1_i == HALT_ARG);
  end
endmodule

// File: rtl/cwc_fsm.sv
module cwc_fsm
  import cwc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cwc_cmd_t   cmd_i,
  input  logic       claim_i,
  input  logic       sel_done_i,
  output cwc_state_e state_o,
  output logic       woken_o,
  output logic       accept_o
);
  cwc_state_e st_q, st_d;
  logic       wok_q, wok_d;
  cwc_state_e fallback;

  assign fallback = wok_q ? ST_HALT : ST_IDLE;

  always_comb begin
    st_d     = st_q;
    wok_d    = wok_q;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_i.reqa | cmd_i.wupa) begin
          st_d     = ST_READY;
          wok_d    = 1'b0;
          accept_o = 1'b1;
        end
      end
      ST_HALT: begin
        // only a clean wake leaves halt
        if (cmd_i.wupa) begin
          st_d     = ST_READY;
          wok_d    = 1'b1;
          accept_o = 1'b1;
        end
      end
      default: begin  // ready, active
        if (cmd_i.vld) begin
          if (!cmd_i.ok || cmd_i.short) begin
            st_d  = fallback;
            wok_d = 1'b0;
          end else if (cmd_i.halt) begin
            st_d  = (st_q == ST_ACTIVE) ? ST_HALT : fallback;
            wok_d = 1'b0;
          end else if (claim_i) begin
            accept_o = 1'b1;
          end else begin
            st_d  = fallback;
            wok_d = 1'b0;
          end
        end else if (st_q == ST_READY && sel_done_i) begin
          st_d = ST_ACTIVE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      wok_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wok_q <= wok_d;
    end
  end

  assign state_o = st_q;
  assign woken_o = wok_q;
endmodule

// File: rtl/cwc_resp.sv
module cwc_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic resp_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resp_en_o <= 1'b0;
    else         resp_en_o <= accept_i;
  end
endmodule

// File: rtl/card_wait_ctrl.sv
module card_wait_ctrl
  import cwc_pkg::*;
#(
  parameter int unsigned SHORT_W = 7,
  parameter int unsigned LEN_W = 5,
  parameter logic [SHORT_W-1:0] REQ_CODE = 7'h26,
  parameter logic [SHORT_W-1:0] WAKE_CODE = 7'h52,
  parameter logic [7:0] HALT_OP = 8'h50,
  parameter logic [7:0] HALT_ARG = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_vld_i,
  input  logic             frame_err_i,
  input  logic             frame_short_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [7:0]       frame_b0_i,
  input  logic [7:0]       frame_b1_i,
  input  logic             claim_i,
  input  logic             sel_done_i,
  output logic [1:0]       state_o,
  output logic             woken_o,
  output logic             resp_en_o
);
  cwc_cmd_t   cmd;
  cwc_state_e state;
  logic       accept;

  cwc_decode #(
    .SHORT_W  (SHORT_W),
    .LEN_W    (LEN_W),
    .REQ_CODE (REQ_CODE),
    .WAKE_CODE(WAKE_CODE),
    .HALT_OP  (HALT_OP),
    .HALT_ARG (HALT_ARG)
  ) u_decode (
    .vld_i  (frame_vld_i),
    .err_i  (frame_err_i),
    .short_i(frame_short_i),
    .len_i  (frame_len_i),
    .b0_i   (frame_b0_i),
    .b1_i   (frame_b1_i),
    .cmd_o  (cmd)
  );

  cwc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .claim_i   (claim_i),
    .sel_done_i(sel_done_i),
    .state_o   (state),
    .woken_o   (woken_o),
    .accept_o  (accept)
  );

  cwc_resp u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .resp_en_o(resp_en_o)
  );

  assign state_o = state;
endmodule

// File: rtl/card_wait_chk.sv
module card_wait_chk #(
  parameter int unsigned SHORT_W = 7,
  parameter logic [SHORT_W-1:0] WAKE_CODE = 7'h52
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_vld_i,
  input logic       frame_err_i,
  input logic       frame_short_i,
  input logic [7:0] frame_b0_i,
  input logic       sel_done_i,
  input logic [1:0] state_o,
  input logic       woken_o,
  input logic       resp_en_o
);
  localparam logic [1:0] SIdle = 2'd0, SReady = 2'd1, SActive = 2'd2, SHalt = 2'd3;

  logic wake_in;
  assign wake_in = frame_vld_i & ~frame_err_i & frame_short_i &
                   (frame_b0_i[SHORT_W-1:0] == WAKE_CODE);

  // R3
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SHalt && !wake_in) |=> (state_o == SHalt && !resp_en_o));

  // R3
  halt_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SHalt && wake_in) |=> (state_o == SReady && woken_o && resp_en_o));

  // R2
  idle_no_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SIdle) |=> (state_o == SIdle || state_o == SReady));

  // R4
  sel_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SReady && sel_done_i && !frame_vld_i) |=> (state_o == SActive));

  // R7
  woken_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    woken_o |-> (state_o == SReady || state_o == SActive));

  // R9
  resp_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !resp_en_o);

  // R5
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == SActive && frame_vld_i ##1 state_o == SHalt) |-> !resp_en_o);
endmodule

bind card_wait_ctrl card_wait_chk #(
  .SHORT_W  (SHORT_W),
  .WAKE_CODE(WAKE_CODE)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_vld_i  (frame_vld_i),
  .frame_err_i  (frame_err_i),
  .frame_short_i(frame_short_i),
  .frame_b0_i   (frame_b0_i),
  .sel_done_i   (sel_done_i),
  .state_o      (state_o),
  .woken_o      (woken_o),
  .resp_en_o    (resp_en_o)
);

// File: tb/card_wait_ctrl_tb.sv
module card_wait_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_vld_i = 1'b0;
  logic       frame_err_i = 1'b0;
  logic       frame_short_i = 1'b0;
  logic [4:0] frame_len_i = '0;
  logic [7:0] frame_b0_i = '0;
  logic [7:0] frame_b1_i = '0;
  logic       claim_i = 1'b0;
  logic       sel_done_i = 1'b0;
  logic [1:0] state_o;
  logic       woken_o;
  logic       resp_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_st = 0;
  int m_wok = 0;
  int m_resp = 0;

  always #5 clk_i = ~clk_i;

  card_wait_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_vld_i(frame_vld_i),
    .frame_err_i(frame_err_i), .frame_short_i(frame_short_i),
    .frame_len_i(frame_len_i), .frame_b0_i(frame_b0_i), .frame_b1_i(frame_b1_i),
    .claim_i(claim_i), .sel_done_i(sel_done_i), .state_o(state_o),
    .woken_o(woken_o), .resp_en_o(resp_en_o)
  );

  task automatic cmp(string tag);
    checks++;
    if (int'(state_o) != m_st || int'(woken_o) != m_wok || int'(resp_en_o) != m_resp) begin
      errors++;
      $display("FAIL %s state/woken/resp act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               tag, state_o, woken_o, resp_en_o, m_st, m_wok, m_resp);
    end
  endtask

  // called at a negedge; applies inputs, models next edge, checks after it
  task automatic step(string tag, bit vld, bit err, bit sh, int len,
                      int b0, int b1, bit clm, bit sel);
    bit ok, req, wak, hlt;
    int fb, n_st, n_wok, n_resp;
    frame_vld_i = vld; frame_err_i = err; frame_short_i = sh;
    frame_len_i = 5'(len); frame_b0_i = 8'(b0); frame_b1_i = 8'(b1);
    claim_i = clm; sel_done_i = sel;
    ok  = vld && !err;
    req = ok && sh && ((b0 & 'h7f) == 'h26);
    wak = ok && sh && ((b0 & 'h7f) == 'h52);
    hlt = ok && !sh && len == 2 && (b0 & 'hff) == 'h50 && (b1 & 'hff) == 0;
    fb = (m_wok != 0) ? 3 : 0;
    n_st = m_st; n_wok = m_wok; n_resp = 0;
    if (m_st == 0) begin
      if (req || wak) begin n_st = 1; n_wok = 0; n_resp = 1; end
    end else if (m_st == 3) begin
      if (wak) begin n_st = 1; n_wok = 1; n_resp = 1; end
    end else if (vld) begin
      if (!ok || sh) begin n_st = fb; n_wok = 0; end
      else if (hlt) begin n_st = (m_st == 2) ? 3 : fb; n_wok = 0; end
      else if (clm) n_resp = 1;
      else begin n_st = fb; n_wok = 0; end
    end else if (m_st == 1 && sel) n_st = 2;
    @(posedge clk_i);
    @(negedge clk_i);
    m_st = n_st; m_wok = n_wok; m_resp = n_resp;
    cmp(tag);
    frame_vld_i = 1'b0; sel_done_i = 1'b0; claim_i = 1'b0;
  endtask

  task automatic idle_cycle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wake(string tag);  step(tag, 1, 0, 1, 0, 'h52, 0, 0, 0); endtask
  task automatic req(string tag);   step(tag, 1, 0, 1, 0, 'h26, 0, 0, 0); endtask
  task automatic sel(string tag);   step(tag, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic halt(string tag);  step(tag, 1, 0, 0, 2, 'h50, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    m_st = 0; m_wok = 0; m_resp = 0;
    cmp("R1");
    rst_ni = 1'b1;
    idle_cycle("R1");
    // R2: idle ignores noise
    step("R2", 1, 1, 1, 0, 'h26, 0, 0, 0);
    halt("R2");
    step("R2", 1, 0, 0, 3, 'h30, 'h04, 1, 0);
    step("R2", 1, 0, 1, 0, 'h27, 0, 0, 0);
    sel("R4");
    req("R2");
    idle_cycle("R9");
    // R10: frame wins over sel
    step("R10", 1, 0, 0, 4, 'h30, 1, 1, 1);
    sel("R4");
    sel("R4");
    step("R8", 1, 0, 0, 4, 'h30, 2, 1, 0);
    step("R6", 1, 1, 0, 2, 'h50, 0, 0, 0);
    wake("R2");
    sel("R4");
    halt("R5");
    // R3: halt holds
    req("R3");
    halt("R3");
    step("R3", 1, 0, 0, 4, 'h30, 0, 1, 0);
    step("R3", 1, 1, 1, 0, 'h52, 0, 0, 0);
    sel("R3");
    idle_cycle("R3");
    wake("R3");
    step("R7", 1, 0, 0, 4, 'h30, 0, 0, 0);
    wake("R3");
    sel("R4");
    req("R7");
    wake("R3");
    sel("R4");
    step("R6", 1, 0, 0, 2, 'h50, 1, 0, 0);
    wake("R3");
    step("R6", 1, 0, 0, 3, 'h50, 0, 0, 0);
    wake("R3");
    halt("R6");
    wake("R3");
    sel("R4");
    step("R8", 1, 0, 0, 4, 'h30, 5, 1, 0);
    halt("R5");
    wake("R3");
    step("R7", 1, 1, 0, 4, 'h30, 5, 1, 0);
    // R1: async reset mid-operation
    wake("R1");
    sel("R1");
    #2 rst_ni = 1'b0;
    #1 m_st = 0; m_wok = 0; m_resp = 0;
    cmp("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_cycle("R1");
    // mixed stimulus against model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: wake("R9");
        1: req("R9");
        2: halt("R9");
        3: sel("R9");
        4: step("R9", 1, 0, 0, 4, 'h30, 0, 1, $urandom_range(0, 1));
        5: step("R9", 1, 1, $urandom_range(0, 1), 2, 'h50, 0, $urandom_range(0, 1), 0);
        6: step("R9", 1, 0, $urandom_range(0, 1), $urandom_range(0, 4),
                $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1));
        7: step("R9", 1, 0, 0, 2, 'h50, 0, 1, 1);
        default: idle_cycle("R9");
      endcase
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule